// File: doc/BRIEF.md
# Voice Segment Directory Controller

This block keeps the ordered list of recorded voice segments for a voice recorder whose samples live in external serial memory. Each entry holds the first and last memory address of one segment. A segment pointer selects the current segment. Single-cycle command pulses, already debounced, step that pointer forward or backward and open or close a recording. The memory side supplies the current write address and a flag that says memory is exhausted.

A recording is always inserted directly after the current segment. Every later entry moves one place up the list. This move is done one entry per clock while `busy` is high, so the new segment lands in its place without a wide parallel copy. When the list or the memory is full, a record request is refused and the indicator blinks for a fixed window. While a recording is open the indicator is steadily lit. A mode input restricts the list to one segment, which each new recording overwrites.

Top module: `seg_dir`

## Requirements
- R1: After a synchronous reset, and at any time while reset is held, the segment count and the pointer are 0, `busy` and `led` are low, and every entry reads back as start 0 and end 0.
- R2: An accepted recording takes its start address from `wr_addr` in the cycle the record pulse is sampled and its end address from `wr_addr` in the cycle it is closed. On an empty list it becomes segment 1, and the count and the pointer both become 1.
- R3: In multi-segment mode, a recording made while the pointer is N becomes segment N+1. Segments that were N+1 and above move up by one with their addresses unchanged. On close the pointer is N+1 and the count has grown by one.
- R4: In idle, a forward pulse adds one to the pointer and a backward pulse subtracts one. Forward at the last segment and backward at segment 1 (or on an empty list) leave the pointer unchanged. A record pulse takes priority over forward, and forward takes priority over backward.
- R5: `busy` is high from the cycle after an accepted record pulse until the segment is closed. This covers both the renumbering phase and the recording phase. Forward, backward and record pulses that arrive while `busy` is high change nothing.
- R6: In multi-segment mode, a record pulse is refused when the count equals `MAX_SEG` or `mem_full` is high. A refused request leaves the count, the pointer and the table unchanged, and `busy` stays low.
- R7: A refused request starts a blink window of `BLINK_HALVES` half-periods, each lasting `TICK_DIV*HALF_TICKS` clocks. `led` is on during even half-periods, counting from 0 at the cycle after the refused pulse, and off during odd ones. After the window `led` is off. A new refusal restarts the window. The defaults give 3 Hz for 2 s at a 1 MHz clock.
- R8: `led` is steadily high for the whole recording phase.
- R9: When `single_mode` is high, a record pulse is never refused. On close the list holds exactly one segment, the new one, and the count and the pointer are both 1.
- R10: `mem_full` going high during the recording phase closes the segment exactly as a stop pulse would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_rec | input | 1 | Record request pulse |
| cmd_stop | input | 1 | Close the open recording |
| cmd_fwd | input | 1 | Step pointer forward |
| cmd_bwd | input | 1 | Step pointer backward |
| single_mode | input | 1 | High: the list holds at most one segment |
| mem_full | input | 1 | External memory exhausted |
| wr_addr | input | AW | Current memory write address |
| rd_seg | input | $clog2(MAX_SEG+1) | Segment number to read, 1-based; 0 reads zeros |
| rd_start | output | AW | Start address of segment `rd_seg` |
| rd_end | output | AW | End address of segment `rd_seg` |
| seg_count | output | $clog2(MAX_SEG+1) | Number of stored segments |
| seg_ptr | output | $clog2(MAX_SEG+1) | Current segment, 0 when empty |
| busy | output | 1 | Renumbering or recording in progress |
| led | output | 1 | Indicator drive |

## Verification
The bench inserts a segment in the middle of the list and compares every entry against a model. A design that copied entries upward in the wrong order would duplicate one segment and lose another. A design that stopped the copy one entry early would overwrite a neighbour. Navigation pulses and a second record pulse are sent during renumbering and during recording; a design that honoured them would move the pointer or corrupt the insert position. The bench drives refusals from both a full table and a full memory and samples `led` in specific half-periods, which exposes a wrong half-period length, an inverted phase or a window that never ends. Single-mode replacement of a multi-segment list and a reset in the middle of a recording complete the scenarios.

// File: rtl/seg_dir_pkg.sv
package seg_dir_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_REC   = 2'd2
    } dir_state_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int DEPTH = 63,
    parameter int EW    = 32,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [EW-1:0] wdata,
    input  logic [IW-1:0] ridx_a,
    output logic [EW-1:0] rdata_a,
    input  logic [IW-1:0] ridx_b,
    output logic [EW-1:0] rdata_b
);
    localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [EW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we && (int'(widx) < DEPTH)) begin
            mem_q[widx[SW-1:0]] <= wdata;
        end
    end

    always_comb begin
        rdata_a = (int'(ridx_a) < DEPTH) ? mem_q[ridx_a[SW-1:0]] : '0;
        rdata_b = (int'(ridx_b) < DEPTH) ? mem_q[ridx_b[SW-1:0]] : '0;
    end

endmodule

// File: rtl/seg_dir_ctrl.sv
module seg_dir_ctrl
    import seg_dir_pkg::*;
#(
    parameter int MAX_SEG = 63,
    parameter int AW      = 16,
    parameter int CW      = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_rec,
    input  logic            cmd_stop,
    input  logic            cmd_fwd,
    input  logic            cmd_bwd,
    input  logic            single_mode,
    input  logic            mem_full,
    input  logic [AW-1:0]   wr_addr,
    input  logic [2*AW-1:0] src_data,
    output logic [CW-1:0]   src_idx,
    output logic            tbl_we,
    output logic [CW-1:0]   tbl_widx,
    output logic [2*AW-1:0] tbl_wdata,
    output logic [CW-1:0]   seg_count,
    output logic [CW-1:0]   seg_ptr,
    output logic            busy,
    output logic            recording,
    output logic            reject
);
    localparam logic [CW-1:0] FULL_CNT = CW'(MAX_SEG);
    localparam logic [CW-1:0] ONE      = CW'(1);

    typedef struct packed {
        dir_state_e    st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] ptr;
        logic [CW-1:0] sh;
        logic [CW-1:0] tgt;
        logic          single;
        logic [AW-1:0] start;
    } ctrl_t;

    ctrl_t         d, q;
    logic [CW-1:0] sh_dec;

    assign sh_dec = q.sh - ONE;

    always_comb begin
        d         = q;
        tbl_we    = 1'b0;
        tbl_widx  = q.sh;
        tbl_wdata = src_data;
        reject    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cmd_rec) begin
                    if (single_mode) begin
                        d.st     = ST_REC;
                        d.tgt    = '0;
                        d.single = 1'b1;
                        d.start  = wr_addr;
                    end else if ((q.cnt == FULL_CNT) || mem_full) begin
                        reject = 1'b1;
                    end else begin
                        d.single = 1'b0;
                        d.tgt    = q.ptr;
                        d.sh     = q.cnt;
                        d.start  = wr_addr;
                        d.st     = (q.cnt > q.ptr) ? ST_SHIFT : ST_REC;
                    end
                end else if (cmd_fwd) begin
                    if (q.ptr < q.cnt) d.ptr = q.ptr + ONE;
                end else if (cmd_bwd) begin
                    if (q.ptr > ONE) d.ptr = q.ptr - ONE;
                end
            end
            ST_SHIFT: begin
                // copy entry sh-1 into slot sh, walking down to the gap
                tbl_we = 1'b1;
                d.sh   = sh_dec;
                if (sh_dec == q.tgt) d.st = ST_REC;
            end
            ST_REC: begin
                if (cmd_stop || mem_full) begin
                    tbl_we    = 1'b1;
                    tbl_widx  = q.tgt;
                    tbl_wdata = {q.start, wr_addr};
                    d.st      = ST_IDLE;
                    if (q.single) begin
                        d.cnt = ONE;
                        d.ptr = ONE;
                    end else begin
                        d.cnt = q.cnt + ONE;
                        d.ptr = q.tgt + ONE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign src_idx   = sh_dec;
    assign seg_count = q.cnt;
    assign seg_ptr   = q.ptr;
    assign busy      = (q.st != ST_IDLE);
    assign recording = (q.st == ST_REC);

endmodule

// File: rtl/blink_timer.sv
module blink_timer #(
    parameter int TICK_DIV     = 1000,
    parameter int HALF_TICKS   = 167,
    parameter int BLINK_HALVES = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic blink_on
);
    localparam int PW = (TICK_DIV > 1)     ? $clog2(TICK_DIV)       : 1;
    localparam int HW = (HALF_TICKS > 1)   ? $clog2(HALF_TICKS)     : 1;
    localparam int LW = $clog2(BLINK_HALVES + 1);
    localparam logic [PW-1:0] PRE_LAST  = PW'(TICK_DIV - 1);
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_TICKS - 1);
    localparam logic [LW-1:0] WINDOW    = LW'(BLINK_HALVES);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [HW-1:0] half;
        logic [LW-1:0] left;
        logic          phase;
    } blink_t;

    blink_t d, q;
    logic   tick;

    assign tick = (q.pre == PRE_LAST);

    always_comb begin
        d = q;
        if (start) begin
            d      = '0;
            d.left = WINDOW;
        end else if (q.left != '0) begin
            d.pre = tick ? '0 : q.pre + 1'b1;
            if (tick) begin
                if (q.half == HALF_LAST) begin
                    d.half  = '0;
                    d.left  = q.left - 1'b1;
                    d.phase = ~q.phase;
                end else begin
                    d.half = q.half + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign blink_on = (q.left != '0) && !q.phase;

endmodule

// File: rtl/seg_dir.sv
module seg_dir #(
    parameter int MAX_SEG      = 63,
    parameter int AW           = 16,
    parameter int TICK_DIV     = 1000,
    parameter int HALF_TICKS   = 167,
    parameter int BLINK_HALVES = 12,
    localparam int CW          = $clog2(MAX_SEG + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_rec,
    input  logic          cmd_stop,
    input  logic          cmd_fwd,
    input  logic          cmd_bwd,
    input  logic          single_mode,
    input  logic          mem_full,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] rd_seg,
    output logic [AW-1:0] rd_start,
    output logic [AW-1:0] rd_end,
    output logic [CW-1:0] seg_count,
    output logic [CW-1:0] seg_ptr,
    output logic          busy,
    output logic          led
);
    localparam int EW = 2 * AW;

    logic          tbl_we;
    logic [CW-1:0] tbl_widx;
    logic [EW-1:0] tbl_wdata;
    logic [CW-1:0] src_idx;
    logic [EW-1:0] src_data;
    logic [EW-1:0] rd_data;
    logic [CW-1:0] rd_slot;
    logic          recording;
    logic          reject;
    logic          blink_on;

    // segment 0 maps to an out-of-range slot and reads as zero
    assign rd_slot = rd_seg - CW'(1);

    seg_dir_ctrl #(.MAX_SEG(MAX_SEG), .AW(AW), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst),
        .cmd_rec(cmd_rec), .cmd_stop(cmd_stop),
        .cmd_fwd(cmd_fwd), .cmd_bwd(cmd_bwd),
        .single_mode(single_mode), .mem_full(mem_full),
        .wr_addr(wr_addr), .src_data(src_data), .src_idx(src_idx),
        .tbl_we(tbl_we), .tbl_widx(tbl_widx), .tbl_wdata(tbl_wdata),
        .seg_count(seg_count), .seg_ptr(seg_ptr),
        .busy(busy), .recording(recording), .reject(reject)
    );

    seg_table #(.DEPTH(MAX_SEG), .EW(EW), .IW(CW)) u_table (
        .clk(clk), .rst(rst),
        .we(tbl_we), .widx(tbl_widx), .wdata(tbl_wdata),
        .ridx_a(src_idx), .rdata_a(src_data),
        .ridx_b(rd_slot), .rdata_b(rd_data)
    );

    blink_timer #(
        .TICK_DIV(TICK_DIV), .HALF_TICKS(HALF_TICKS), .BLINK_HALVES(BLINK_HALVES)
    ) u_blink (
        .clk(clk), .rst(rst), .start(reject), .blink_on(blink_on)
    );

    assign rd_start = rd_data[EW-1:AW];
    assign rd_end   = rd_data[AW-1:0];
    assign led      = recording | blink_on;

endmodule

// File: rtl/seg_dir_chk.sv
module seg_dir_chk #(
    parameter int MAX_SEG = 63,
    parameter int CW      = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_rec,
    input logic          cmd_stop,
    input logic          cmd_fwd,
    input logic          cmd_bwd,
    input logic          single_mode,
    input logic          mem_full,
    input logic [CW-1:0] seg_count,
    input logic [CW-1:0] seg_ptr,
    input logic          busy,
    input logic          led
);
    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(seg_count) <= MAX_SEG);

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (seg_ptr <= seg_count) && ((seg_ptr == '0) == (seg_count == '0)));

    // R4
    fwd_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cmd_rec && cmd_fwd && (seg_ptr == seg_count)) |=> $stable(seg_ptr));

    // R4
    bwd_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cmd_rec && !cmd_fwd && cmd_bwd && (seg_ptr <= CW'(1))) |=> $stable(seg_ptr));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd_stop && !mem_full) |=> (busy && $stable(seg_count) && $stable(seg_ptr)));

    // R6
    refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_rec && !single_mode && ((int'(seg_count) == MAX_SEG) || mem_full))
        |=> (!busy && led && $stable(seg_count) && $stable(seg_ptr)));

endmodule

bind seg_dir seg_dir_chk #(.MAX_SEG(MAX_SEG), .CW(CW)) u_chk (
    .clk(clk), .rst(rst),
    .cmd_rec(cmd_rec), .cmd_stop(cmd_stop),
    .cmd_fwd(cmd_fwd), .cmd_bwd(cmd_bwd),
    .single_mode(single_mode), .mem_full(mem_full),
    .seg_count(seg_count), .seg_ptr(seg_ptr),
    .busy(busy), .led(led)
);

// File: tb/sim_seg_dir.sv
module sim_seg_dir;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_SEG    = 6;
    localparam int AW         = 16;
    localparam int CW         = $clog2(MAX_SEG + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_rec = 1'b0, cmd_stop = 1'b0, cmd_fwd = 1'b0, cmd_bwd = 1'b0;
    logic          single_mode = 1'b0, mem_full = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] rd_seg = '0;
    logic [AW-1:0] rd_start, rd_end;
    logic [CW-1:0] seg_count, seg_ptr;
    logic          busy, led;

    int checks = 0;
    int errors = 0;
    int mstart [1:MAX_SEG+1];
    int mend   [1:MAX_SEG+1];
    int mcount = 0;
    int mptr   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_dir #(
        .MAX_SEG(MAX_SEG), .AW(AW), .TICK_DIV(4), .HALF_TICKS(2), .BLINK_HALVES(12)
    ) u0 (
        .clk(clk), .rst(rst),
        .cmd_rec(cmd_rec), .cmd_stop(cmd_stop), .cmd_fwd(cmd_fwd), .cmd_bwd(cmd_bwd),
        .single_mode(single_mode), .mem_full(mem_full), .wr_addr(wr_addr),
        .rd_seg(rd_seg), .rd_start(rd_start), .rd_end(rd_end),
        .seg_count(seg_count), .seg_ptr(seg_ptr), .busy(busy), .led(led)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic pulse(input logic r, input logic s, input logic f, input logic b);
        @(negedge clk);
        cmd_rec = r; cmd_stop = s; cmd_fwd = f; cmd_bwd = b;
        @(negedge clk);
        cmd_rec = 1'b0; cmd_stop = 1'b0; cmd_fwd = 1'b0; cmd_bwd = 1'b0;
    endtask

    task automatic check_dir(input string req);
        chk({req, " count"}, int'(seg_count), mcount);
        chk({req, " pointer"}, int'(seg_ptr), mptr);
        for (int j = 1; j <= mcount; j++) begin
            rd_seg = CW'(j);
            #1;
            chk($sformatf("%s seg%0d start", req, j), int'(rd_start), mstart[j]);
            chk($sformatf("%s seg%0d end", req, j), int'(rd_end), mend[j]);
        end
    endtask

    task automatic model_insert(input int s, input int e);
        for (int j = mcount; j > mptr; j--) begin
            mstart[j+1] = mstart[j];
            mend[j+1]   = mend[j];
        end
        mstart[mptr+1] = s;
        mend[mptr+1]   = e;
        mcount++;
        mptr++;
    endtask

    task automatic wait_led(input string req);
        int n = 0;
        while (!led && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk({req, " reached recording"}, int'(led), 1);
    endtask

    task automatic record(input int s, input int e);
        wr_addr = AW'(s);
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        wait_led("R2");
        wr_addr = AW'(e);
        pulse(1'b0, 1'b1, 1'b0, 1'b0);
        model_insert(s, e);
    endtask

    task automatic blink_pattern(input string req);
        // entered at the negedge after the refused pulse: offset 0
        chk({req, " led at refusal"}, int'(led), 1);
        chk({req, " busy stays low"}, int'(busy), 0);
        repeat (3) @(posedge clk); #1;
        chk("R7 led offset 3 on", int'(led), 1);
        repeat (8) @(posedge clk); #1;
        chk("R7 led offset 11 off", int'(led), 0);
        repeat (8) @(posedge clk); #1;
        chk("R7 led offset 19 on", int'(led), 1);
        repeat (66) @(posedge clk); #1;
        chk("R7 led offset 85 on", int'(led), 1);
        repeat (4) @(posedge clk); #1;
        chk("R7 led offset 89 off", int'(led), 0);
        repeat (11) @(posedge clk); #1;
        chk("R7 led after window", int'(led), 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 count in reset", int'(seg_count), 0);
        rst = 1'b0;
        @(negedge clk);
        mcount = 0; mptr = 0;
        chk("R1 count", int'(seg_count), 0);
        chk("R1 pointer", int'(seg_ptr), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 led", int'(led), 0);
        rd_seg = CW'(1); #1;
        chk("R1 seg1 start", int'(rd_start), 0);
        chk("R1 seg1 end", int'(rd_end), 0);
    endtask

    task automatic t_first();
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R4 fwd on empty list", int'(seg_ptr), 0);
        record(16'h0010, 16'h001f);
        check_dir("R2");
    endtask

    task automatic t_append();
        record(16'h0020, 16'h002f);
        record(16'h0030, 16'h003f);
        check_dir("R3 append");
    endtask

    task automatic t_nav();
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R4 fwd at last", int'(seg_ptr), 3);
        pulse(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R4 bwd step", int'(seg_ptr), 2);
        pulse(1'b0, 1'b0, 1'b0, 1'b1);
        pulse(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R4 bwd at first", int'(seg_ptr), 1);
        pulse(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R4 fwd beats bwd", int'(seg_ptr), 2);
        mptr = 2;
    endtask

    task automatic t_insert();
        record(16'h0040, 16'h004f);
        check_dir("R3 insert");
    endtask

    task automatic t_busy();
        pulse(1'b0, 1'b0, 1'b0, 1'b1);
        pulse(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R4 pointer at 1", int'(seg_ptr), 1);
        mptr = 1;
        wr_addr = 16'h0050;
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 busy in shift", int'(busy), 1);
        chk("R8 led off in shift", int'(led), 0);
        wr_addr = 16'h0055;
        pulse(1'b1, 1'b0, 1'b1, 1'b0);
        wait_led("R5");
        pulse(1'b0, 1'b0, 1'b0, 1'b1);
        pulse(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R5 busy in recording", int'(busy), 1);
        chk("R8 led steady", int'(led), 1);
        chk("R5 pointer held", int'(seg_ptr), 1);
        wr_addr = 16'h005f;
        pulse(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R5 busy drops on close", int'(busy), 0);
        model_insert(16'h0050, 16'h005f);
        check_dir("R5");
    endtask

    task automatic t_mem_refuse();
        mem_full = 1'b1;
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        mem_full = 1'b0;
        blink_pattern("R6 mem_full");
        check_dir("R6 mem_full");
    endtask

    task automatic t_mem_close();
        wr_addr = 16'h0060;
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        wait_led("R10");
        wr_addr = 16'h006a;
        mem_full = 1'b1;
        @(negedge clk);
        mem_full = 1'b0;
        chk("R10 closed by mem_full", int'(busy), 0);
        model_insert(16'h0060, 16'h006a);
        check_dir("R10");
    endtask

    task automatic t_full();
        chk("R6 table full", int'(seg_count), MAX_SEG);
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        blink_pattern("R6 full");
        check_dir("R6 full");
    endtask

    task automatic t_single();
        single_mode = 1'b1;
        wr_addr = 16'h0070;
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9 accepted when full", int'(busy), 1);
        wait_led("R9");
        wr_addr = 16'h007f;
        pulse(1'b0, 1'b1, 1'b0, 1'b0);
        mcount = 1; mptr = 1;
        mstart[1] = 16'h0070; mend[1] = 16'h007f;
        check_dir("R9");
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R4 fwd single", int'(seg_ptr), 1);
        single_mode = 1'b0;
    endtask

    task automatic t_reset_mid();
        wr_addr = 16'h0080;
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        wait_led("R1");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mid count", int'(seg_count), 0);
        chk("R1 mid pointer", int'(seg_ptr), 0);
        chk("R1 mid busy", int'(busy), 0);
        chk("R1 mid led", int'(led), 0);
        rd_seg = CW'(1); #1;
        chk("R1 mid seg1 end", int'(rd_end), 0);
    endtask

    initial begin
        t_reset();
        t_first();
        t_append();
        t_nav();
        t_insert();
        t_busy();
        t_mem_refuse();
        t_mem_close();
        t_full();
        t_single();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule